// File: doc/BRIEF.md
# Bus-Matching Byte-Swap Port Adapter

This block joins a FIFO pair that moves only 36-bit long words to an external port that can move 36, 18 or 9 bits per transfer. For traffic leaving the FIFO it takes one long word and hands it out over one, two or four port transfers. For traffic entering the FIFO it gathers one, two or four port transfers and pushes the finished long word. On both paths one of four byte-order permutations can be applied to each long word. Inside a word the four 9-bit bytes are named A, B, C, D from the most significant end, and narrow transfers always go in that order.

The port width and lane choice are set by a registered select. A select value reserved for mailbox traffic bypasses the FIFO paths completely. It leaves the stored width alone, so a long word that is partly moved can carry on afterwards. The FIFO storage and the mailbox registers lie outside this block. The read side expects first-word-fall-through data with an empty flag. The write side gives a push strobe and a word in the same cycle, and takes a full flag.

Top module: `bus_match_adapter`

## Requirements
- R1: `size_sel` and `endian_sel` are registered on every rising edge, and a transfer uses the value registered at an earlier edge. A width change presented in the same cycle as a transfer does not affect that transfer. Size codes are 00 long word (one transfer), 01 word (two), 10 byte (four) and 11 mailbox.
- R2: In a cycle with `size_sel` = 11, no FIFO pop or push occurs and `rd_data` does not change. The registered width and lane select keep their values, so a partly read or partly written word carries on with its next piece in the following transfer.
- R3: For word and byte widths, `endian_sel` = 0 uses the upper lanes (bits 35:18 or 35:27) and `endian_sel` = 1 uses the lower lanes (bits 17:0 or 8:0). A long word uses all 36 bits.
- R4: A read that needs a new long word pops the FIFO and puts out the first piece. Later reads at the same width and lane select put out the remaining pieces in order A-to-D, or upper half then lower half, and do not pop.
- R5: A read whose registered width or lane select differs from that of the word in progress pops a new long word and drops the unread pieces of the old one.
- R6: A write pushes only on the transfer that completes the long word: the first at long width, the second at word width, the fourth at byte width. The push comes in the same cycle as that transfer. Earlier pieces do not push.
- R7: A write whose registered width or lane select differs from that of the partial word in progress starts a fresh long word and discards the gathered pieces.
- R8: Swap codes are 00 none, 01 ABCD to DCBA, 10 ABCD to CDAB and 11 ABCD to BADC. The bits inside a byte are never reordered. The code is taken at the first transfer of each long word, and later transfers of that word ignore `swap_sel`.
- R9: On reads the word is swapped first and then split by width. On writes the pieces are assembled by width first and the word is swapped as it is pushed.
- R10: During a narrow read the lanes of `rd_data` outside the selected ones keep their previous values.
- R11: After reset, `rd_data` is zero, no partial word is pending on either path, and the registered width is long word with lane select 0.
- R12: A read that needs a new word while the FIFO is empty is ignored and `rd_data` holds. A write transfer that would complete a word while `wrf_full` is high is ignored and can be repeated later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| size_sel | input | 2 | Transfer width code, or the mailbox code 11 |
| endian_sel | input | 1 | Lane select for narrow widths: 0 upper, 1 lower |
| swap_sel | input | 2 | Byte permutation code, taken at the first transfer of each word |
| rd_req | input | 1 | Port read transfer this cycle |
| rd_data | output | 36 | Registered port read data |
| rdf_data | input | 36 | Head word of the read-side FIFO |
| rdf_empty | input | 1 | Read-side FIFO empty |
| rdf_pop | output | 1 | Pop the read-side FIFO at this edge |
| wr_req | input | 1 | Port write transfer this cycle |
| wr_data | input | 36 | Port write data |
| wrf_data | output | 36 | Long word pushed to the write-side FIFO |
| wrf_push | output | 1 | Push strobe for the write-side FIFO |
| wrf_full | input | 1 | Write-side FIFO full |

## Verification
Every combination of width, lane select and swap code is used to read a long word out in pieces and then write the same pieces back. Because each swap is its own inverse, a correct design pushes the original word. This separates the four permutations from one another and confirms that reads swap before splitting while writes swap after assembly. Changing `swap_sel` on the later pieces of each word shows whether the code is held for the whole word, and filling unused write lanes with a fixed junk pattern shows whether stray lanes leak into the word. Separate sequences cover the following: a width change in the same cycle as a transfer, a mailbox cycle in the middle of a word, a width change that drops a half-read word or discards a half-written one, a read from an empty FIFO, and a full FIFO at the completing write.

// File: rtl/bm_pkg.sv
`timescale 1ns/1ps
package bm_pkg;

  typedef enum logic [1:0] {
    SZ_LONG = 2'b00,
    SZ_WORD = 2'b01,
    SZ_BYTE = 2'b10,
    SZ_MBOX = 2'b11
  } bm_size_e;

  localparam int BM_LANES = 4;

  // transfers needed per long word
  function automatic int xfers(bm_size_e s);
    case (s)
      SZ_WORD: return 2;
      SZ_BYTE: return 4;
      default: return 1;
    endcase
  endfunction

  // lane index xor mask that realises each permutation
  function automatic logic [1:0] swap_mask(logic [1:0] m);
    case (m)
      2'b01:   return 2'd3;
      2'b10:   return 2'd2;
      2'b11:   return 2'd1;
      default: return 2'd0;
    endcase
  endfunction

endpackage

// File: rtl/bm_cfg_latch.sv
`timescale 1ns/1ps
module bm_cfg_latch (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       size_in,
  input  logic             endian_in,
  output bm_pkg::bm_size_e size_q,
  output logic             endian_q
);
  import bm_pkg::*;

  logic is_mbox;
  assign is_mbox = (size_in == 2'b11);

  always_ff @(posedge clk) begin
    if (rst) begin
      size_q   <= SZ_LONG;
      endian_q <= 1'b0;
    end else if (!is_mbox) begin
      size_q   <= bm_size_e'(size_in);
      endian_q <= endian_in;
    end
  end

  // R2: a mailbox cycle leaves the stored width untouched
  p_mbox_keeps_cfg_r2: assert property (@(posedge clk) disable iff (rst)
    (size_in == 2'b11) |=> ($stable(size_q) && $stable(endian_q)));

endmodule

// File: rtl/bm_lane_swap.sv
`timescale 1ns/1ps
module bm_lane_swap #(
  parameter int LANE_W = 9
) (
  input  logic [bm_pkg::BM_LANES*LANE_W-1:0] din,
  input  logic [1:0]                         mode,
  output logic [bm_pkg::BM_LANES*LANE_W-1:0] dout
);
  localparam int LANES  = bm_pkg::BM_LANES;
  localparam int WORD_W = LANES * LANE_W;

  logic [1:0]        mask;
  logic [LANE_W-1:0] lane_in [LANES];

  assign mask = bm_pkg::swap_mask(mode);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [1:0] src;
    assign lane_in[i] = din[WORD_W-1-i*LANE_W -: LANE_W];
    assign src        = 2'(i) ^ mask;
    assign dout[WORD_W-1-i*LANE_W -: LANE_W] = lane_in[src];
  end

endmodule

// File: rtl/bm_unpack.sv
`timescale 1ns/1ps
module bm_unpack #(
  parameter int LANE_W = 9
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req,
  input  bm_pkg::bm_size_e                   size_q,
  input  logic                               endian_q,
  input  logic [1:0]                         swap_in,
  input  logic [bm_pkg::BM_LANES*LANE_W-1:0] fifo_data,
  input  logic                               fifo_empty,
  output logic                               fifo_pop,
  output logic [bm_pkg::BM_LANES*LANE_W-1:0] port_data
);
  import bm_pkg::*;
  localparam int LANES  = BM_LANES;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] held, swapped, src, nxt;
  logic              live, fresh, fire, last;
  logic [1:0]        pos, pos_eff;
  bm_size_e          w_size;
  logic              w_end;
  int                n, k, base;

  bm_lane_swap #(.LANE_W(LANE_W)) u_swap (
    .din(fifo_data), .mode(swap_in), .dout(swapped));

  assign fresh    = !live || (size_q != w_size) || (endian_q != w_end);
  assign fire     = req && (!fresh || !fifo_empty);
  assign fifo_pop = req && fresh && !fifo_empty;
  assign pos_eff  = fresh ? 2'd0 : pos;
  assign src      = fresh ? swapped : held;

  always_comb begin
    n    = xfers(size_q);
    k    = LANES / n;
    base = endian_q ? (LANES - k) : 0;
    last = ((int'(pos_eff) + 1) == n);
    nxt  = port_data;
    for (int j = 0; j < LANES; j++) begin
      if (j >= base && j < base + k)
        nxt[WORD_W-1-j*LANE_W -: LANE_W] =
          src[WORD_W-1-(int'(pos_eff)*k + j - base)*LANE_W -: LANE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      port_data <= '0;
      held      <= '0;
      live      <= 1'b0;
      pos       <= 2'd0;
      w_size    <= SZ_LONG;
      w_end     <= 1'b0;
    end else if (fire) begin
      port_data <= nxt;
      live      <= !last;
      pos       <= last ? 2'd0 : pos_eff + 2'd1;
      if (fresh) begin
        held   <= swapped;
        w_size <= size_q;
        w_end  <= endian_q;
      end
    end
  end

  // R12: no transfer, or nothing to fetch, leaves the port data alone
  p_read_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (!req || (fresh && fifo_empty)) |=> $stable(port_data));

  // R10: an upper-lane byte read leaves the other three lanes as they were
  p_narrow_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (fire && size_q == SZ_BYTE && !endian_q) |=> $stable(port_data[WORD_W-LANE_W-1:0]));

endmodule

// File: rtl/bm_pack.sv
`timescale 1ns/1ps
module bm_pack #(
  parameter int LANE_W = 9
) (
  input  logic                               clk,
  input  logic                               rst,
  input  logic                               req,
  input  bm_pkg::bm_size_e                   size_q,
  input  logic                               endian_q,
  input  logic [1:0]                         swap_in,
  input  logic [bm_pkg::BM_LANES*LANE_W-1:0] port_data,
  input  logic                               fifo_full,
  output logic                               fifo_push,
  output logic [bm_pkg::BM_LANES*LANE_W-1:0] fifo_data
);
  import bm_pkg::*;
  localparam int LANES  = BM_LANES;
  localparam int WORD_W = LANES * LANE_W;

  logic [WORD_W-1:0] acc, merged;
  logic              live, fresh, last, accept;
  logic [1:0]        pos, pos_eff, w_swap, swap_eff;
  bm_size_e          w_size;
  logic              w_end;
  int                n, k, base, lo;

  assign fresh     = !live || (size_q != w_size) || (endian_q != w_end);
  assign pos_eff   = fresh ? 2'd0 : pos;
  assign swap_eff  = fresh ? swap_in : w_swap;
  assign accept    = req && !(last && fifo_full);
  assign fifo_push = req && last && !fifo_full;

  always_comb begin
    n      = xfers(size_q);
    k      = LANES / n;
    base   = endian_q ? (LANES - k) : 0;
    lo     = int'(pos_eff) * k;
    last   = ((int'(pos_eff) + 1) == n);
    merged = fresh ? '0 : acc;
    for (int d = 0; d < LANES; d++) begin
      if (d >= lo && d < lo + k)
        merged[WORD_W-1-d*LANE_W -: LANE_W] =
          port_data[WORD_W-1-(base + d - lo)*LANE_W -: LANE_W];
    end
  end

  bm_lane_swap #(.LANE_W(LANE_W)) u_swap (
    .din(merged), .mode(swap_eff), .dout(fifo_data));

  always_ff @(posedge clk) begin
    if (rst) begin
      acc    <= '0;
      live   <= 1'b0;
      pos    <= 2'd0;
      w_swap <= 2'd0;
      w_size <= SZ_LONG;
      w_end  <= 1'b0;
    end else if (accept) begin
      acc  <= merged;
      live <= !last;
      pos  <= last ? 2'd0 : pos_eff + 2'd1;
      if (fresh) begin
        w_swap <= swap_in;
        w_size <= size_q;
        w_end  <= endian_q;
      end
    end
  end

  // R12: never push into a full FIFO
  p_push_respects_full_r12: assert property (@(posedge clk) disable iff (rst)
    fifo_full |-> !fifo_push);

  // R6: a long-width write completes a word by itself
  p_long_push_r6: assert property (@(posedge clk) disable iff (rst)
    (req && size_q == SZ_LONG && !fifo_full) |-> fifo_push);

  // R8: the swap code stays frozen while a word is being gathered
  p_swap_frozen_r8: assert property (@(posedge clk) disable iff (rst)
    (req && !fresh) |=> $stable(w_swap));

endmodule

// File: rtl/bus_match_adapter.sv
`timescale 1ns/1ps
module bus_match_adapter #(
  parameter int LANE_W = 9,
  localparam int WORD_W = bm_pkg::BM_LANES * LANE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        size_sel,
  input  logic              endian_sel,
  input  logic [1:0]        swap_sel,
  input  logic              rd_req,
  output logic [WORD_W-1:0] rd_data,
  input  logic [WORD_W-1:0] rdf_data,
  input  logic              rdf_empty,
  output logic              rdf_pop,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] wrf_data,
  output logic              wrf_push,
  input  logic              wrf_full
);
  bm_pkg::bm_size_e size_q;
  logic             endian_q, mbox, rd_go, wr_go;

  assign mbox  = (size_sel == 2'b11);
  assign rd_go = rd_req && !mbox;
  assign wr_go = wr_req && !mbox;

  bm_cfg_latch u_cfg (
    .clk(clk), .rst(rst), .size_in(size_sel), .endian_in(endian_sel),
    .size_q(size_q), .endian_q(endian_q));

  bm_unpack #(.LANE_W(LANE_W)) u_rd (
    .clk(clk), .rst(rst), .req(rd_go), .size_q(size_q), .endian_q(endian_q),
    .swap_in(swap_sel), .fifo_data(rdf_data), .fifo_empty(rdf_empty),
    .fifo_pop(rdf_pop), .port_data(rd_data));

  bm_pack #(.LANE_W(LANE_W)) u_wr (
    .clk(clk), .rst(rst), .req(wr_go), .size_q(size_q), .endian_q(endian_q),
    .swap_in(swap_sel), .port_data(wr_data), .fifo_full(wrf_full),
    .fifo_push(wrf_push), .fifo_data(wrf_data));

  // R2: a mailbox cycle never touches either FIFO
  p_mbox_no_fifo_r2: assert property (@(posedge clk) disable iff (rst)
    (size_sel == 2'b11) |-> (!rdf_pop && !wrf_push));

endmodule

// File: tb/bus_match_adapter_test.sv
`timescale 1ns/1ps
module bus_match_adapter_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  size_sel = 2'b00, swap_sel = 2'b00;
  logic        endian_sel = 1'b0, rd_req = 1'b0, wr_req = 1'b0, wrf_full = 1'b0;
  logic [35:0] wr_data = '0, rdf_data = '0;
  logic        rdf_empty = 1'b1;
  logic [35:0] rd_data, wrf_data;
  logic        rdf_pop, wrf_push;

  bus_match_adapter uut (
    .clk(clk), .rst(rst), .size_sel(size_sel), .endian_sel(endian_sel),
    .swap_sel(swap_sel), .rd_req(rd_req), .rd_data(rd_data),
    .rdf_data(rdf_data), .rdf_empty(rdf_empty), .rdf_pop(rdf_pop),
    .wr_req(wr_req), .wr_data(wr_data), .wrf_data(wrf_data),
    .wrf_push(wrf_push), .wrf_full(wrf_full));

  always #10 clk = ~clk;

  localparam logic [35:0] JUNK = 36'h5A5A5A5A5;

  int          nchk = 0, nfail = 0;
  bit          reported = 0, pop_seen = 0;
  logic        nf = 1'b0;
  logic [35:0] exp_rd = '0;
  logic [35:0] rfifo[$];
  bit          ep_q[$], epu_q[$];
  logic [35:0] epd_q[$], erd_q[$];
  string       ctag_q[$], rtag_q[$];

  function automatic int nx(logic [1:0] sz);
    return (sz == 2'b01) ? 2 : (sz == 2'b10) ? 4 : 1;
  endfunction

  function automatic logic [35:0] bsw(logic [35:0] w, logic [1:0] m);
    logic [35:0] r;
    int mk;
    mk = (m == 2'b01) ? 3 : (m == 2'b10) ? 2 : (m == 2'b11) ? 1 : 0;
    for (int i = 0; i < 4; i++) r[35-9*i -: 9] = w[35-9*(i ^ mk) -: 9];
    return r;
  endfunction

  // put piece 'pos' of 'src' onto its port lanes over 'prev'
  function automatic logic [35:0] place(logic [35:0] prev, logic [35:0] src,
                                        logic [1:0] sz, logic en, int pos);
    logic [35:0] r;
    int k, b;
    k = 4 / nx(sz);
    b = en ? 4 - k : 0;
    r = prev;
    for (int j = 0; j < k; j++) r[35-9*(b+j) -: 9] = src[35-9*(pos*k+j) -: 9];
    return r;
  endfunction

  task automatic refresh();
    rdf_empty = (rfifo.size() == 0);
    rdf_data  = rdf_empty ? '0 : rfifo[0];
  endtask

  task automatic idle(logic [1:0] sz, logic en);
    @(negedge clk); #1;
    rd_req = 0; wr_req = 0; size_sel = sz; endian_sel = en; wrf_full = nf;
  endtask

  // driver: one cycle of stimulus plus its expected results
  task automatic step(logic r, logic w, logic [35:0] wd, logic [1:0] sw,
                      logic [1:0] sz, logic en, bit ep, bit epu,
                      logic [35:0] epd, string tag);
    @(negedge clk); #1;
    rd_req = r; wr_req = w; wr_data = wd; swap_sel = sw;
    size_sel = sz; endian_sel = en; wrf_full = nf;
    ep_q.push_back(ep); epu_q.push_back(epu); epd_q.push_back(epd);
    ctag_q.push_back(tag);
    erd_q.push_back(exp_rd); rtag_q.push_back(tag);
  endtask

  // monitor: strobes and push word, sampled just before the edge
  initial forever begin
    @(negedge clk); #8;
    pop_seen = rdf_pop;
    if (ep_q.size() > 0) begin
      bit ep, epu;
      logic [35:0] epd;
      string tg;
      ep = ep_q.pop_front(); epu = epu_q.pop_front();
      epd = epd_q.pop_front(); tg = ctag_q.pop_front();
      nchk++;
      if (rdf_pop !== ep || wrf_push !== epu || (epu && wrf_data !== epd)) begin
        nfail++;
        $display("FAIL %s: pop=%b push=%b data=%h expected pop=%b push=%b data=%h",
                 tg, rdf_pop, wrf_push, wrf_data, ep, epu, epd);
      end
    end
  end

  // monitor: registered read data, sampled after the edge
  initial forever begin
    @(posedge clk); #5;
    if (erd_q.size() > 0) begin
      logic [35:0] e;
      string tg;
      e = erd_q.pop_front(); tg = rtag_q.pop_front();
      nchk++;
      if (rd_data !== e) begin
        nfail++;
        $display("FAIL %s: rd_data=%h expected %h", tg, rd_data, e);
      end
    end
  end

  // read-side FIFO model
  initial forever begin
    @(posedge clk); #1;
    if (pop_seen && rfifo.size() > 0) begin
      void'(rfifo.pop_front());
      refresh();
    end
  end

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    end
  endtask

  initial begin
    #(20 * 150000);
    nfail++;
    $display("FAIL watchdog: run did not complete, expected completion");
    report();
    $finish;
  end

  initial begin
    logic [35:0] w, sw_w;
    refresh();
    repeat (3) @(negedge clk);
    #1 rst = 0;

    // R11: reset state, then a long read works with no setup
    step(0, 0, '0, 2'b00, 2'b00, 0, 0, 0, '0, "R11 reset");
    rfifo.push_back(36'h123456789); refresh();
    exp_rd = 36'h123456789;
    step(1, 0, '0, 2'b00, 2'b00, 0, 1, 0, '0, "R11 default long");

    // R3 R4 R6 R8 R9 R10: round trip over every combination
    for (int sz = 0; sz < 3; sz++)
      for (int en = 0; en < 2; en++)
        for (int s = 0; s < 4; s++) begin
          int c, n;
          c = sz * 8 + en * 4 + s;
          n = nx(2'(sz));
          w = {9'(c*7+1), 9'(c*13+40), 9'(c*29+100), 9'(c*3+300)};
          sw_w = bsw(w, 2'(s));
          idle(2'(sz), en[0]);
          rfifo.push_back(w); refresh();
          for (int i = 0; i < n; i++) begin
            exp_rd = place(exp_rd, sw_w, 2'(sz), en[0], i);
            step(1, 0, '0, (i == 0) ? 2'(s) : ~2'(s), 2'(sz), en[0],
                 (i == 0), 0, '0, "R3 R4 R8 R9 R10 read");
          end
          for (int i = 0; i < n; i++)
            step(0, 1, place(JUNK, sw_w, 2'(sz), en[0], i),
                 (i == 0) ? 2'(s) : ~2'(s), 2'(sz), en[0],
                 0, (i == n - 1), w, "R3 R6 R8 R9 write");
        end

    // R1: width change in the same cycle as a read takes effect one edge later
    idle(2'b00, 0);
    rfifo.push_back(36'h0AB0CD0EF); rfifo.push_back(36'h111222333); refresh();
    exp_rd = 36'h0AB0CD0EF;
    step(1, 0, '0, 2'b00, 2'b10, 0, 1, 0, '0, "R1 old width used");
    w = 36'h111222333;
    for (int i = 0; i < 4; i++) begin
      exp_rd = place(exp_rd, w, 2'b10, 0, i);
      step(1, 0, '0, 2'b00, 2'b10, 0, (i == 0), 0, '0, "R1 R4 new width");
    end

    // R5: width change drops the unread remainder
    idle(2'b10, 1);
    rfifo.push_back(36'h1F2E3D4C5); rfifo.push_back(36'h0F0E0D0C0); refresh();
    exp_rd = place(exp_rd, 36'h1F2E3D4C5, 2'b10, 1, 0);
    step(1, 0, '0, 2'b00, 2'b10, 1, 1, 0, '0, "R5 first byte");
    idle(2'b01, 1);
    w = 36'h0F0E0D0C0;
    exp_rd = place(exp_rd, w, 2'b01, 1, 0);
    step(1, 0, '0, 2'b00, 2'b01, 1, 1, 0, '0, "R5 refetch");
    exp_rd = place(exp_rd, w, 2'b01, 1, 1);
    step(1, 0, '0, 2'b00, 2'b01, 1, 0, 0, '0, "R5 R4 second half");

    // R2: mailbox cycle in the middle of a byte read and a byte write
    idle(2'b10, 0);
    w = 36'h1A2B3C4D5;
    rfifo.push_back(w); refresh();
    exp_rd = place(exp_rd, w, 2'b10, 0, 0);
    step(1, 0, '0, 2'b00, 2'b10, 0, 1, 0, '0, "R2 byte A");
    step(1, 1, 36'hFFFFFFFFF, 2'b00, 2'b11, 0, 0, 0, '0, "R2 mailbox cycle");
    for (int i = 1; i < 4; i++) begin
      exp_rd = place(exp_rd, w, 2'b10, 0, i);
      step(1, 0, '0, 2'b00, 2'b10, 0, 0, 0, '0, "R2 resume read");
    end
    w = 36'h0C3A5F1E7;
    step(0, 1, place(JUNK, w, 2'b10, 0, 0), 2'b00, 2'b10, 0, 0, 0, '0, "R2 write A");
    step(0, 1, 36'h123123123, 2'b00, 2'b11, 0, 0, 0, '0, "R2 mailbox write");
    for (int i = 1; i < 4; i++)
      step(0, 1, place(JUNK, w, 2'b10, 0, i), 2'b00, 2'b10, 0,
           0, (i == 3), w, "R2 resume write");

    // R7: width change mid-write discards the partial word
    idle(2'b10, 0);
    step(0, 1, 36'h1FF000000, 2'b00, 2'b10, 0, 0, 0, '0, "R7 partial byte");
    step(0, 1, 36'h0EE000000, 2'b00, 2'b10, 0, 0, 0, '0, "R7 partial byte");
    idle(2'b01, 0);
    w = 36'h0A1B2C3D4;
    sw_w = bsw(w, 2'b01);
    step(0, 1, place(JUNK, sw_w, 2'b01, 0, 0), 2'b01, 2'b01, 0, 0, 0, '0, "R7 restart");
    step(0, 1, place(JUNK, sw_w, 2'b01, 0, 1), 2'b00, 2'b01, 0, 0, 1, w, "R7 fresh word");

    // R12: empty read ignored, full write ignored then retried
    idle(2'b00, 0);
    step(1, 0, '0, 2'b00, 2'b00, 0, 0, 0, '0, "R12 empty read");
    nf = 1;
    step(0, 1, 36'h0DEADBEEF, 2'b00, 2'b00, 0, 0, 0, '0, "R12 full long");
    idle(2'b10, 0);
    w = 36'h1C0FFEE11;
    for (int i = 0; i < 4; i++)
      step(0, 1, place(JUNK, w, 2'b10, 0, i), 2'b00, 2'b10, 0, 0, 0, '0, "R12 full byte");
    nf = 0;
    step(0, 1, place(JUNK, w, 2'b10, 0, 3), 2'b00, 2'b10, 0, 0, 1, w, "R12 retry byte");
    idle(2'b00, 0);
    step(0, 1, 36'h0DEADBEEF, 2'b00, 2'b00, 0, 0, 1, 36'h0DEADBEEF, "R12 retry long");

    idle(2'b00, 0);
    repeat (3) @(negedge clk);
    report();
    $finish;
  end

endmodule